// File: doc/BRIEF.md
# Floating-Point Exception Flag and Trap Controller

This block keeps the exception state of a floating-point arithmetic unit. Each time the unit completes an operation it presents a strobe with a five-bit vector of exception events, together with the opcode and both operand values of that operation. The block holds one sticky status flag and one trap-enable bit for each of the five exceptions.

Software reaches the block through a small register port. Through it, software reads the flags, clears selected flags, writes the enables, acknowledges a trap, and reads what was captured at the faulting operation. A disabled exception only marks its flag, and the arithmetic unit goes on with its default result. An enabled exception raises a trap request in the same cycle as the event. It also freezes the opcode, the operands and the event vector of that operation, so that a handler can read them.

Event bit positions are used in the event vector, the flag register and the enable register alike: bit 0 overflow, bit 1 underflow, bit 2 divide-by-zero, bit 3 invalid, bit 4 inexact. Register addresses are: 0 flags (read; write 1 clears), 1 enables (read/write), 2 trap status (read: bit 0 pending, bits 5:1 captured event vector; any write acknowledges), 3 captured opcode, 4 captured operand A, 5 captured operand B. Any other address reads as zero. Narrower fields read zero-extended.

Top module: `fpx_except_ctrl`

## Requirements
- R1: After reset the flags, the enables, the trap request, the pending bit and all capture registers read 0.
- R2: On a cycle with `ev_valid` high, every set bit of `ev_bits` sets its flag (bit 0 overflow, 1 underflow, 2 divide-by-zero, 3 invalid, 4 inexact), and the new value is readable at address 0 from the next cycle.
- R3: A flag stays set across later operations, including ones with no exception bits. Only a write to address 0 with a 1 in that bit position clears it, and 0 bits leave their flags untouched.
- R4: If a clear write and an event hit the same flag in the same cycle, the flag ends up set.
- R5: The enables are written and read at address 0x1 in bits 4:0, using the R2 bit positions, and reset to 0.
- R6: An event whose set bits all have their enable at 0 raises no trap and changes neither the pending bit nor the capture registers. It only sets flags.
- R7: `trap_req` goes high in the same cycle as `ev_valid` when the AND of `ev_bits` and the enables is nonzero.
- R8: Once raised, the trap stays pending (`trap_req` high, address 2 bit 0 set) until a write to address 2. An acknowledge in the same cycle as a new trapping event leaves the trap pending.
- R9: A trapping event captures its opcode (address 3), operand A (address 4), operand B (address 5) and its event vector (address 2 bits 5:1).
- R10: While a trap is pending and not being acknowledged, a further trapping event leaves all capture registers unchanged. An event in the same cycle as the acknowledge is captured.
- R11: With `ev_valid` low, `ev_bits` has no effect on the flags or on the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Operation-complete strobe |
| ev_bits | input | 5 | Exception events of the completing operation |
| ev_opcode | input | OPC_W | Opcode of the completing operation |
| ev_opa | input | OPD_W | Operand A of the completing operation |
| ev_opb | input | OPD_W | Operand B of the completing operation |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| trap_req | output | 1 | Trap request to the handler |

## Verification
The bench builds the block with a 4-bit opcode, 8-bit operands and a 16-bit register port. These narrow widths keep every captured field small enough to compute and compare directly. With them, the bench sweeps all 32 enable masks against all 32 event vectors. For each pair it derives the expected same-cycle trap, the flags, the capture contents and the frozen-capture behaviour arithmetically from the mask and the vector. Directed sequences then cover the same-cycle races: a clear against an event, and an acknowledge against a new trap.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
    localparam int EXC_COUNT = 5;
    localparam int ADDR_W    = 3;

    localparam int BIT_OVF   = 0;
    localparam int BIT_UNF   = 1;
    localparam int BIT_DIVZ  = 2;
    localparam int BIT_INV   = 3;
    localparam int BIT_INX   = 4;

    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TRAP   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_OPC    = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_OPA    = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_OPB    = 3'd5;
endpackage

// File: rtl/fpx_flag_bank.sv
module fpx_flag_bank #(
    parameter int N = fpx_pkg::EXC_COUNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev_valid,
    input  logic [N-1:0] ev_bits,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    input  logic         en_we,
    input  logic [N-1:0] en_wdata,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables
);
    typedef struct packed {
        logic [N-1:0] flags;
        logic [N-1:0] en;
    } bank_t;

    bank_t st_d, st_q;
    logic [N-1:0] set_v, clr_v, nxt_flag;

    // Per-exception flag cell: a new event takes priority over a clear.
    for (genvar i = 0; i < N; i++) begin : g_cell
        assign set_v[i]    = ev_valid & ev_bits[i];
        assign clr_v[i]    = clr_we & clr_mask[i];
        assign nxt_flag[i] = set_v[i] | (st_q.flags[i] & ~clr_v[i]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = nxt_flag;
        if (en_we) begin
            st_d.en = en_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags   = st_q.flags;
    assign enables = st_q.en;

    p_flag_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> ((st_q.flags & $past(ev_bits)) == $past(ev_bits)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((st_q.flags & $past(st_q.flags)) == $past(st_q.flags)));

    p_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !ev_valid) |=> ((st_q.flags & $past(clr_mask)) == '0));

    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(st_q.en));

    p_idle_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !clr_we) |=> $stable(st_q.flags));
endmodule

// File: rtl/fpx_trap_capture.sv
module fpx_trap_capture #(
    parameter int N     = fpx_pkg::EXC_COUNT,
    parameter int OPC_W = 8,
    parameter int OPD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [N-1:0]     ev_bits,
    input  logic [N-1:0]     enables,
    input  logic [OPC_W-1:0] ev_opcode,
    input  logic [OPD_W-1:0] ev_opa,
    input  logic [OPD_W-1:0] ev_opb,
    input  logic             ack_we,
    output logic             trap_req,
    output logic             pending,
    output logic [N-1:0]     cap_cause,
    output logic [OPC_W-1:0] cap_opc,
    output logic [OPD_W-1:0] cap_opa,
    output logic [OPD_W-1:0] cap_opb
);
    typedef struct packed {
        logic             pending;
        logic [N-1:0]     cause;
        logic [OPC_W-1:0] opc;
        logic [OPD_W-1:0] opa;
        logic [OPD_W-1:0] opb;
    } trap_t;

    trap_t st_d, st_q;
    logic  hit;
    logic  take;

    assign hit  = ev_valid && ((ev_bits & enables) != '0);
    assign take = hit && (!st_q.pending || ack_we);

    always_comb begin
        st_d         = st_q;
        st_d.pending = hit | (st_q.pending & ~ack_we);
        if (take) begin
            st_d.cause = ev_bits;
            st_d.opc   = ev_opcode;
            st_d.opa   = ev_opa;
            st_d.opb   = ev_opb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_req  = st_q.pending | hit;
    assign pending   = st_q.pending;
    assign cap_cause = st_q.cause;
    assign cap_opc   = st_q.opc;
    assign cap_opa   = st_q.opa;
    assign cap_opb   = st_q.opb;

    p_trap_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && !ack_we) |=> st_q.pending);

    p_capture_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && !ack_we) |=> ($stable(st_q.opc) && $stable(st_q.opa)
                                       && $stable(st_q.opb) && $stable(st_q.cause)));

    p_capture_opcode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !st_q.pending) |=> (st_q.opc == $past(ev_opcode) && st_q.cause == $past(ev_bits)));

    p_masked_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !st_q.pending) |=> (!st_q.pending && $stable(st_q.opa)));
endmodule

// File: rtl/fpx_reg_if.sv
module fpx_reg_if #(
    parameter int N      = fpx_pkg::EXC_COUNT,
    parameter int OPC_W  = 8,
    parameter int OPD_W  = 32,
    parameter int RW     = 32,
    parameter int ADDR_W = fpx_pkg::ADDR_W
) (
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    input  logic [N-1:0]      flags,
    input  logic [N-1:0]      enables,
    input  logic              pending,
    input  logic [N-1:0]      cap_cause,
    input  logic [OPC_W-1:0]  cap_opc,
    input  logic [OPD_W-1:0]  cap_opa,
    input  logic [OPD_W-1:0]  cap_opb,
    output logic              clr_we,
    output logic [N-1:0]      clr_mask,
    output logic              en_we,
    output logic [N-1:0]      en_wdata,
    output logic              ack_we,
    output logic [RW-1:0]     reg_rdata
);
    import fpx_pkg::*;

    typedef struct packed {
        logic          clr_we;
        logic          en_we;
        logic          ack_we;
        logic [RW-1:0] rdata;
    } port_t;

    port_t pt;
    logic  unused_wbits;

    assign unused_wbits = ^reg_wdata[RW-1:N];

    always_comb begin
        pt        = '0;
        pt.clr_we = reg_we && (reg_addr == ADR_FLAGS);
        pt.en_we  = reg_we && (reg_addr == ADR_ENABLE);
        pt.ack_we = reg_we && (reg_addr == ADR_TRAP);
        unique case (reg_addr)
            ADR_FLAGS:  pt.rdata[N-1:0]     = flags;
            ADR_ENABLE: pt.rdata[N-1:0]     = enables;
            ADR_TRAP: begin
                pt.rdata[0]   = pending;
                pt.rdata[N:1] = cap_cause;
            end
            ADR_OPC:    pt.rdata[OPC_W-1:0] = cap_opc;
            ADR_OPA:    pt.rdata[OPD_W-1:0] = cap_opa;
            ADR_OPB:    pt.rdata[OPD_W-1:0] = cap_opb;
            default:    pt.rdata            = '0;
        endcase
    end

    assign clr_we    = pt.clr_we;
    assign en_we     = pt.en_we;
    assign ack_we    = pt.ack_we;
    assign clr_mask  = reg_wdata[N-1:0];
    assign en_wdata  = reg_wdata[N-1:0];
    assign reg_rdata = pt.rdata;

    always_comb begin
        a_single_write_r3: assert ($countones({pt.clr_we, pt.en_we, pt.ack_we}) <= 1);
    end
endmodule

// File: rtl/fpx_except_ctrl.sv
module fpx_except_ctrl #(
    parameter int OPC_W = 8,
    parameter int OPD_W = 32,
    parameter int RW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ev_valid,
    input  logic [fpx_pkg::EXC_COUNT-1:0] ev_bits,
    input  logic [OPC_W-1:0]           ev_opcode,
    input  logic [OPD_W-1:0]           ev_opa,
    input  logic [OPD_W-1:0]           ev_opb,
    input  logic                       reg_we,
    input  logic [fpx_pkg::ADDR_W-1:0] reg_addr,
    input  logic [RW-1:0]              reg_wdata,
    output logic [RW-1:0]              reg_rdata,
    output logic                       trap_req
);
    localparam int N = fpx_pkg::EXC_COUNT;

    logic [N-1:0]     flags, enables, clr_mask, en_wdata, cap_cause;
    logic             clr_we, en_we, ack_we, pending;
    logic [OPC_W-1:0] cap_opc;
    logic [OPD_W-1:0] cap_opa, cap_opb;

    fpx_flag_bank #(.N(N)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_bits(ev_bits),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .en_we(en_we), .en_wdata(en_wdata),
        .flags(flags), .enables(enables)
    );

    fpx_trap_capture #(.N(N), .OPC_W(OPC_W), .OPD_W(OPD_W)) u_trap (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(ev_valid), .ev_bits(ev_bits), .enables(enables),
        .ev_opcode(ev_opcode), .ev_opa(ev_opa), .ev_opb(ev_opb),
        .ack_we(ack_we), .trap_req(trap_req), .pending(pending),
        .cap_cause(cap_cause), .cap_opc(cap_opc),
        .cap_opa(cap_opa), .cap_opb(cap_opb)
    );

    fpx_reg_if #(.N(N), .OPC_W(OPC_W), .OPD_W(OPD_W), .RW(RW)) u_regs (
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .flags(flags), .enables(enables), .pending(pending),
        .cap_cause(cap_cause), .cap_opc(cap_opc),
        .cap_opa(cap_opa), .cap_opb(cap_opb),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .en_we(en_we), .en_wdata(en_wdata),
        .ack_we(ack_we), .reg_rdata(reg_rdata)
    );

    p_trap_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ((ev_bits & enables) != '0)) |-> trap_req);

    p_no_trap_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !(ev_valid && ((ev_bits & enables) != '0))) |-> !trap_req);
endmodule

// File: tb/test_fpx_except_ctrl.sv
module test_fpx_except_ctrl;
    localparam int OPC_W = 4;
    localparam int OPD_W = 8;
    localparam int RW    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ev_valid = 1'b0;
    logic [4:0]       ev_bits = '0;
    logic [OPC_W-1:0] ev_opcode = '0;
    logic [OPD_W-1:0] ev_opa = '0, ev_opb = '0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [RW-1:0]    reg_wdata = '0;
    logic [RW-1:0]    reg_rdata;
    logic             trap_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    fpx_except_ctrl #(.OPC_W(OPC_W), .OPD_W(OPD_W), .RW(RW)) i_fpx_except_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bits(ev_bits),
        .ev_opcode(ev_opcode), .ev_opa(ev_opa), .ev_opb(ev_opb),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_req(trap_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [RW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fire(input logic [4:0] b, input logic [OPC_W-1:0] o,
                        input logic [OPD_W-1:0] a, input logic [OPD_W-1:0] bb,
                        output logic t);
        @(negedge clk);
        ev_valid = 1'b1; ev_bits = b; ev_opcode = o; ev_opa = a; ev_opb = bb;
        #1 t = trap_req;
        @(negedge clk);
        ev_valid = 1'b0; ev_bits = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [RW-1:0] d;
        logic t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 trap_req", {31'd0, trap_req}, 0);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            chk("R1 register", {16'd0, d}, 0);
        end

        // Exhaustive sweep over enable masks and event vectors
        for (int m = 0; m < 32; m++) begin
            for (int e = 0; e < 32; e++) begin
                logic [4:0]       mm = m[4:0];
                logic [4:0]       ee = e[4:0];
                logic             hit = ((mm & ee) != 0);
                logic [OPC_W-1:0] op = ee[3:0] ^ mm[3:0];
                logic [OPD_W-1:0] oa = {mm[2:0], ee};
                logic [OPD_W-1:0] ob = ~oa;
                wr(3'd1, {11'd0, mm});
                wr(3'd0, 16'h001F);
                wr(3'd2, 16'h0001);
                rd(3'd1, d);
                chk("R5 enables", {16'd0, d}, {27'd0, mm});
                fire(ee, op, oa, ob, t);
                chk(hit ? "R7 trap same cycle" : "R6 no trap masked", {31'd0, t}, {31'd0, hit});
                rd(3'd0, d);
                chk("R2 flags", {16'd0, d}, {27'd0, ee});
                rd(3'd2, d);
                chk("R8 pending bit", {31'd0, d[0]}, {31'd0, hit});
                if (hit) begin
                    chk("R9 cause", {27'd0, d[5:1]}, {27'd0, ee});
                    rd(3'd3, d); chk("R9 opcode", {16'd0, d}, {28'd0, op});
                    rd(3'd4, d); chk("R9 operand A", {16'd0, d}, {24'd0, oa});
                    rd(3'd5, d); chk("R9 operand B", {16'd0, d}, {24'd0, ob});
                end
                fire(5'd0, 4'hF, 8'h00, 8'h00, t);
                chk("R8 trap held", {31'd0, t}, {31'd0, hit});
                rd(3'd0, d);
                chk("R3 sticky after clean op", {16'd0, d}, {27'd0, ee});
                if (hit) begin
                    fire(5'h1F, ~op, ob, oa, t);
                    rd(3'd4, d); chk("R10 operand A frozen", {16'd0, d}, {24'd0, oa});
                    rd(3'd3, d); chk("R10 opcode frozen", {16'd0, d}, {28'd0, op});
                    wr(3'd2, 16'h0001);
                    #1 chk("R8 trap released", {31'd0, trap_req}, 0);
                end
            end
        end

        // R3: selective clear leaves other flags
        wr(3'd1, 16'h0000);
        fire(5'h1F, 4'h0, 8'h00, 8'h00, t);
        wr(3'd0, 16'h0005);
        rd(3'd0, d);
        chk("R3 selective clear", {16'd0, d}, 32'h1A);

        // R4: event and clear hit the same flag in one cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h001F;
        ev_valid = 1'b1; ev_bits = 5'b00100;
        @(negedge clk);
        reg_we = 1'b0; ev_valid = 1'b0; ev_bits = '0;
        rd(3'd0, d);
        chk("R4 event beats clear", {16'd0, d}, 32'h04);

        // R11: bits without strobe are ignored
        wr(3'd1, 16'h001F);
        wr(3'd0, 16'h001F);
        @(negedge clk);
        ev_valid = 1'b0; ev_bits = 5'h1F;
        #1 chk("R11 no trap without strobe", {31'd0, trap_req}, 0);
        @(negedge clk);
        ev_bits = '0;
        rd(3'd0, d);
        chk("R11 flags untouched", {16'd0, d}, 0);

        // R8/R10: acknowledge together with a new trapping event
        fire(5'b00001, 4'h3, 8'h11, 8'h22, t);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 16'h0001;
        ev_valid = 1'b1; ev_bits = 5'b01000; ev_opcode = 4'h9; ev_opa = 8'h77; ev_opb = 8'h88;
        @(negedge clk);
        reg_we = 1'b0; ev_valid = 1'b0; ev_bits = '0;
        #1 chk("R8 ack with new trap stays", {31'd0, trap_req}, 1);
        rd(3'd3, d); chk("R10 capture at ack", {16'd0, d}, 32'h9);
        rd(3'd2, d); chk("R9 cause at ack", {16'd0, d}, 32'h11);
        rd(3'd7, d); chk("R9 unmapped reads zero", {16'd0, d}, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule